// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block is the control side of a synchronous burst read from a memory organised in 16-bit words. A host starts a burst by holding the active-low address strobe low for one clock while it drives a word address. The sequencer captures that address and counts a fixed number of wait states. It then presents one array address per clock to the storage array and raises a ready flag that tells the host when the word on the data pins is good. The storage array, the command decoder and the pad drivers sit outside this block.

Four address orderings are available. The continuous ordering walks upward without limit and rolls over from the top word to word zero. Whenever it steps across a 64-word aligned block it inserts one gap cycle, in which ready drops and the address holds. The three wrapping orderings stay inside a naturally aligned group of 8, 16 or 32 words. They cover the whole group once, starting at the captured word, and then end the burst. A four-bit setting register chooses the ordering, the timing of ready (with the data, or one cycle ahead of it) and the clock edge on which the outputs move. The register is loaded from the address bus by a write strobe, and only while no burst is running.

The ready output reports the burst's progress and the host cannot stall it: no back-pressure exists, and a burst ends only when its group is complete, when the host terminates it, or when a new strobe restarts it. All pins are plain control and address signals.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset the array address is 0 and ready is low. The settings are continuous ordering, rising-edge outputs and ready aligned with the data.
- R2: An address strobe sampled low at edge E captures the address bus. With ready aligned, the captured address appears with ready high after edge E+WAIT_CYCLES (7 by default), and ready stays low in between.
- R3: In continuous ordering the address rises by one on each data cycle. After the all-ones address it continues at 0.
- R4: In continuous ordering, after the data cycle for a word at offset 63 within its 64-word block, there is one cycle with ready low and the address unchanged. The next block's first word follows.
- R5: Ordering code 01, 10 and 11 gives a group of 8, 16 and 32 words respectively. The address counts up to the group's last word, continues at the group's first word, and delivers exactly one group's worth of words. Ready then drops and the address holds on the last word delivered.
- R6: In a wrapping ordering the address bits above the group size never change during the burst, even at the top of the address space.
- R7: With the ready-timing bit at 0, ready is high in each cycle that precedes a data cycle, instead of during the data cycle itself. This holds across wait states, the block gap and the end of a group.
- R8: With the edge bit at 0, the address and ready outputs change half a clock period after the rising edge that advances the sequencer. They follow the same sequence as with the bit at 1.
- R9: A burst-terminate sampled high at an edge during a burst sends the block idle at that edge, and ready goes low.
- R10: A new strobe during a burst captures the new address and restarts the wait count from zero.
- R11: A setting write sampled while a burst is in progress is ignored, and the next burst uses the old settings.
- R12: A setting write sampled while idle, with the strobe high, loads the settings from the address bus. Bits 16:15 hold the ordering code (00 continuous), bit 17 the edge bit (1 rising, 0 falling) and bit 18 the ready-timing bit (1 with data, 0 one cycle early).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_n | input | 1 | Active-low address strobe; starts a burst |
| addr_in | input | ADDR_W | Word address bus; also carries setting bits 18:15 |
| cfg_wr | input | 1 | Setting-register write strobe |
| burst_stop | input | 1 | Terminates the current burst |
| arr_addr | output | ADDR_W | Current array word address |
| rdy | output | 1 | Data-ready indication |

## Verification
The hardest case to reach is a gap cycle while the ready timing is early and the outputs move on the falling edge. There, ready must already drop on the word before the boundary, and the change must show half a cycle late. The stimulus loads each combination of settings through idle-time writes. It then starts bursts a few words below a 64-word boundary, below the top of the address space, and just inside a wrap group, so every such event falls within a few cycles of the first data word. The outputs are sampled both a quarter and three quarters of a period after each rising edge, which tells the two edge settings apart.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_DATA = 2'd2,
    SEQ_GAP  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    ORD_LINEAR = 2'b00,
    ORD_GRP8   = 2'b01,
    ORD_GRP16  = 2'b10,
    ORD_GRP32  = 2'b11
  } burst_order_e;

  // packed so that bit 3 maps to address bit 18, bits 1:0 to 16:15
  typedef struct packed {
    logic         rdy_with_data;
    logic         rise_edge;
    burst_order_e order;
  } seq_cfg_t;

  localparam int CFG_FIELD_LSB = 15;
  localparam int CFG_FIELD_W   = $bits(seq_cfg_t);
  localparam int BLK_BITS      = 6;
  localparam int GRP_MIN_BITS  = 3;
  localparam int GRP_VARIANTS  = 3;

  localparam seq_cfg_t CFG_DEFAULT = '{
    rdy_with_data: 1'b1,
    rise_edge:     1'b1,
    order:         ORD_LINEAR
  };

endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
  import brs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  logic     adv_n,
  input  logic     busy,
  input  seq_cfg_t wdata,
  output seq_cfg_t cfg
);

  logic load;

  // writes land only between bursts and never on a strobe edge
  assign load = wr && adv_n && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_DEFAULT;
    end else if (load) begin
      cfg <= wdata;
    end
  end

  // R11
  cfg_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && busy) |=> $stable(cfg));

  // R12
  cfg_load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && adv_n && !busy) |=> (cfg == $past(wdata)));

endmodule

// File: rtl/brs_ptr_step.sv
module brs_ptr_step
  import brs_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic [AW-1:0]       cur_ptr,
  input  burst_order_e        order,
  input  logic [BLK_BITS-1:0] served,
  output logic [AW-1:0]       lin_next,
  output logic [AW-1:0]       wrap_next,
  output logic                blk_end,
  output logic                grp_last
);

  logic [AW-1:0]           cand [GRP_VARIANTS];
  logic [GRP_VARIANTS-1:0] last_vec;

  assign lin_next = cur_ptr + AW'(1);
  assign blk_end  = &cur_ptr[BLK_BITS-1:0];

  // one wrap candidate per group size: low bits roll, high bits frozen
  for (genvar g = 0; g < GRP_VARIANTS; g++) begin : g_grp
    localparam int B = GRP_MIN_BITS + g;
    assign cand[g]     = {cur_ptr[AW-1:B], cur_ptr[B-1:0] + B'(1)};
    assign last_vec[g] = (served == BLK_BITS'((1 << B) - 1));
  end

  always_comb begin
    wrap_next = lin_next;
    grp_last  = 1'b0;
    unique case (order)
      ORD_GRP8: begin
        wrap_next = cand[0];
        grp_last  = last_vec[0];
      end
      ORD_GRP16: begin
        wrap_next = cand[1];
        grp_last  = last_vec[1];
      end
      ORD_GRP32: begin
        wrap_next = cand[2];
        grp_last  = last_vec[2];
      end
      default: begin
        wrap_next = lin_next;
        grp_last  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/brs_seq_ctrl.sv
module brs_seq_ctrl
  import brs_pkg::*;
#(
  parameter int AW          = 22,
  parameter int WAIT_CYCLES = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv_n,
  input  logic [AW-1:0]       addr_in,
  input  logic                stop,
  input  burst_order_e        order,
  input  logic [AW-1:0]       lin_next,
  input  logic [AW-1:0]       wrap_next,
  input  logic                blk_end,
  input  logic                grp_last,
  output logic [AW-1:0]       ptr,
  output logic [BLK_BITS-1:0] served,
  output logic                valid,
  output logic                valid_pred,
  output logic                busy
);

  localparam int WCW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
  localparam logic [WCW-1:0] WC_LAST = WCW'(WAIT_CYCLES - 1);

  seq_state_e          state, state_n;
  logic [AW-1:0]       ptr_n;
  logic [WCW-1:0]      wcnt, wcnt_n;
  logic [BLK_BITS-1:0] served_n;
  logic                is_wrap;

  assign is_wrap = (order != ORD_LINEAR);

  always_comb begin
    state_n  = state;
    ptr_n    = ptr;
    wcnt_n   = wcnt;
    served_n = served;
    if (!adv_n) begin
      state_n  = SEQ_WAIT;
      ptr_n    = addr_in;
      wcnt_n   = '0;
      served_n = '0;
    end else if (stop && state != SEQ_IDLE) begin
      state_n = SEQ_IDLE;
    end else begin
      unique case (state)
        SEQ_WAIT: begin
          if (wcnt == WC_LAST) state_n = SEQ_DATA;
          else                 wcnt_n  = wcnt + WCW'(1);
        end
        SEQ_DATA: begin
          if (is_wrap) begin
            if (grp_last) begin
              state_n = SEQ_IDLE;
            end else begin
              ptr_n    = wrap_next;
              served_n = served + BLK_BITS'(1);
            end
          end else if (blk_end) begin
            state_n = SEQ_GAP;
          end else begin
            ptr_n = lin_next;
          end
        end
        SEQ_GAP: begin
          state_n = SEQ_DATA;
          ptr_n   = lin_next;
        end
        default: state_n = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      ptr    <= '0;
      wcnt   <= '0;
      served <= '0;
    end else begin
      state  <= state_n;
      ptr    <= ptr_n;
      wcnt   <= wcnt_n;
      served <= served_n;
    end
  end

  // look-ahead used for early ready: assumes no stop and no new strobe
  always_comb begin
    unique case (state)
      SEQ_WAIT: valid_pred = (wcnt == WC_LAST);
      SEQ_DATA: valid_pred = is_wrap ? !grp_last : !blk_end;
      SEQ_GAP:  valid_pred = 1'b1;
      default:  valid_pred = 1'b0;
    endcase
  end

  assign valid = (state == SEQ_DATA);
  assign busy  = (state != SEQ_IDLE);

  // R2
  strobe_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |=> (state == SEQ_WAIT && ptr == $past(addr_in) && !valid));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_wrap && valid && adv_n && !stop && ptr[BLK_BITS-1:0] != '1)
      |=> (valid && ptr == $past(ptr) + AW'(1)));

  // R4
  block_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_wrap && valid && adv_n && !stop && ptr[BLK_BITS-1:0] == '1)
      |=> (!valid && $stable(ptr)));

  // R6
  wrap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wrap && busy && adv_n) |=> $stable(ptr[AW-1:BLK_BITS]));

  // R7
  pred_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_pred && adv_n && !stop) |=> valid);

  // R7
  pred_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_pred && adv_n) |=> !valid);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && adv_n && busy) |=> !busy);

endmodule

// File: rtl/brs_edge_out.sv
module brs_edge_out #(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_edge,
  input  logic [AW-1:0] addr_c,
  input  logic          rdy_c,
  output logic [AW-1:0] arr_addr,
  output logic          rdy
);

  logic [AW-1:0] addr_fall;
  logic          rdy_fall;

  // half-cycle retiming stage for the falling-edge setting
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_fall <= '0;
      rdy_fall  <= 1'b0;
    end else begin
      addr_fall <= addr_c;
      rdy_fall  <= rdy_c;
    end
  end

  assign arr_addr = rise_edge ? addr_c : addr_fall;
  assign rdy      = rise_edge ? rdy_c  : rdy_fall;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import brs_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int WAIT_CYCLES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cfg_wr,
  input  logic              burst_stop,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              rdy
);

  seq_cfg_t            cfg;
  seq_cfg_t            cfg_wdata;
  logic [ADDR_W-1:0]   ptr, lin_next, wrap_next;
  logic [BLK_BITS-1:0] served;
  logic                blk_end, grp_last;
  logic                valid, valid_pred, busy;
  logic                rdy_c;

  assign cfg_wdata = seq_cfg_t'(addr_in[CFG_FIELD_LSB +: CFG_FIELD_W]);

  brs_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .adv_n (adv_n),
    .busy  (busy),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  brs_ptr_step #(.AW(ADDR_W)) u_step (
    .cur_ptr   (ptr),
    .order     (cfg.order),
    .served    (served),
    .lin_next  (lin_next),
    .wrap_next (wrap_next),
    .blk_end   (blk_end),
    .grp_last  (grp_last)
  );

  brs_seq_ctrl #(.AW(ADDR_W), .WAIT_CYCLES(WAIT_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_n      (adv_n),
    .addr_in    (addr_in),
    .stop       (burst_stop),
    .order      (cfg.order),
    .lin_next   (lin_next),
    .wrap_next  (wrap_next),
    .blk_end    (blk_end),
    .grp_last   (grp_last),
    .ptr        (ptr),
    .served     (served),
    .valid      (valid),
    .valid_pred (valid_pred),
    .busy       (busy)
  );

  assign rdy_c = cfg.rdy_with_data ? valid : valid_pred;

  brs_edge_out #(.AW(ADDR_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_edge (cfg.rise_edge),
    .addr_c    (ptr),
    .rdy_c     (rdy_c),
    .arr_addr  (arr_addr),
    .rdy       (rdy)
  );

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

  localparam int CLK_T = 20;
  localparam int AW    = 22;
  localparam int WS    = 7;
  localparam int WDOG  = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          adv_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          cfg_wr = 1'b0;
  logic          burst_stop = 1'b0;
  logic [AW-1:0] arr_addr;
  logic          rdy;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  burst_addr_seq #(.ADDR_W(AW), .WAIT_CYCLES(WS)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_n      (adv_n),
    .addr_in    (addr_in),
    .cfg_wr     (cfg_wr),
    .burst_stop (burst_stop),
    .arr_addr   (arr_addr),
    .rdy        (rdy)
  );

  always #(CLK_T/2) clk = ~clk;

  // reference model: phase 0 idle, 1 waiting, 2 data, 3 gap
  int            ph = 0, wc = 0, served = 0, glen;
  logic [AW-1:0] mptr = '0;
  logic [3:0]    mcfg = 4'b1100;
  logic [AW-1:0] e_addr = '0, p_addr = '0;
  logic          e_rdy = 1'b0, p_rdy = 1'b0;
  logic          m_valid, m_pred;

  always @(posedge clk) begin
    p_addr = e_addr;
    p_rdy  = e_rdy;
    if (!rst_n) begin
      ph = 0; wc = 0; served = 0; mptr = '0; mcfg = 4'b1100;
    end else begin
      if (cfg_wr && adv_n && ph == 0) mcfg = addr_in[18:15];
      glen = 1 << (mcfg[1:0] + 2);
      if (!adv_n) begin
        ph = 1; wc = 0; served = 0; mptr = addr_in;
      end else if (burst_stop && ph != 0) begin
        ph = 0;
      end else if (ph == 1) begin
        if (wc == WS - 1) ph = 2;
        else wc++;
      end else if (ph == 2) begin
        if (mcfg[1:0] != 2'b00) begin
          if (served == glen - 1) ph = 0;
          else begin
            served++;
            mptr = (mptr & ~AW'(glen - 1)) | ((mptr + AW'(1)) & AW'(glen - 1));
          end
        end else if (mptr % 64 == 63) ph = 3;
        else mptr = mptr + AW'(1);
      end else if (ph == 3) begin
        mptr = mptr + AW'(1);
        ph = 2;
      end
    end
    glen = 1 << (mcfg[1:0] + 2);
    m_valid = (ph == 2);
    m_pred  = (ph == 1 && wc == WS - 1) || (ph == 3) ||
              (ph == 2 && ((mcfg[1:0] != 2'b00) ? (served + 1 < glen) : (mptr % 64 != 63)));
    e_addr = mptr;
    e_rdy  = mcfg[3] ? m_valid : m_pred;
  end

  task automatic chk(input string when, input logic [AW-1:0] ea, input logic er);
    n_chk++;
    if (arr_addr !== ea || rdy !== er) begin
      n_fail++;
      $display("FAIL %s (%s) t=%0t addr act=%h exp=%h rdy act=%b exp=%b",
               cur_req, when, $time, arr_addr, ea, rdy, er);
    end
  endtask

  // quarter-period sample separates the edge settings, three-quarter is settled
  always @(posedge clk) begin
    #(CLK_T/4);
    if (mcfg[2]) chk("early", e_addr, e_rdy);
    else         chk("early", p_addr, p_rdy);
    #(CLK_T/2);
    chk("late", e_addr, e_rdy);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [AW-1:0] a);
    @(negedge clk);
    adv_n = 1'b0;
    addr_in = a;
    @(negedge clk);
    adv_n = 1'b1;
  endtask

  task automatic cfgw(input logic [3:0] bits);
    @(negedge clk);
    cfg_wr = 1'b1;
    addr_in = AW'(bits) << 15;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic stop_pulse();
    @(negedge clk);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R2: default settings, aligned ready after seven wait states
    cur_req = "R2";
    strobe(22'h000100); idle(12);
    // R3: roll over at the top of the address space
    cur_req = "R3";
    strobe(22'h3FFFFD); idle(14);
    stop_pulse();
    // R4: gap cycle crossing a 64-word block
    cur_req = "R4";
    strobe(22'h00013C); idle(14);
    stop_pulse();
    // R12 then R5: group of 8, code 01
    cur_req = "R12"; cfgw(4'b1101); idle(2);
    cur_req = "R5";  strobe(22'h00025D); idle(20);
    // R5: group of 16, code 10
    cur_req = "R12"; cfgw(4'b1110);
    cur_req = "R5";  strobe(22'h004007); idle(28);
    // R6: group of 32 at the top of the space
    cur_req = "R12"; cfgw(4'b1111);
    cur_req = "R6";  strobe(22'h3FFFFE); idle(44);
    // R7: early ready, continuous across a block and wrap of 8
    cur_req = "R7";
    cfgw(4'b0100); strobe(22'h00007C); idle(16); stop_pulse();
    cfgw(4'b0101); strobe(22'h000013); idle(20);
    // R8: falling-edge outputs, aligned then early ready
    cur_req = "R8";
    cfgw(4'b1000); strobe(22'h000010); idle(14); stop_pulse();
    cfgw(4'b0011); strobe(22'h012345); idle(44);
    cfgw(4'b0000); strobe(22'h0003FC); idle(14); stop_pulse();
    // R9: terminate in data and in wait phases
    cur_req = "R9";
    cfgw(4'b1100);
    strobe(22'h000200); idle(9); stop_pulse(); idle(4);
    strobe(22'h000300); idle(3); stop_pulse(); idle(10);
    // R10: restrobe during wait and during data
    cur_req = "R10";
    strobe(22'h000400); idle(4);
    strobe(22'h000500); idle(9);
    strobe(22'h000600); idle(12);
    stop_pulse();
    // R11: writes during the burst must not take effect
    cur_req = "R11";
    strobe(22'h000700); idle(2);
    cfgw(4'b0011); idle(6);
    cfgw(4'b0001); idle(2);
    stop_pulse(); idle(2);
    strobe(22'h000800); idle(12);
    stop_pulse(); idle(3);
    finish_run();
  end

endmodule